// File: doc/BRIEF.md
# Interrupt Destination Acceptance Filter

This block sits beside one local interrupt controller and decides, for each inter-processor interrupt message it sees, whether that controller takes the message. It holds a 4-bit addressing-format register that selects flat or cluster logical addressing, and resets to flat. The unit's logical ID, its physical ID, the message's 8-bit destination, destination mode, 2-bit shorthand, delivery mode and sender ID feed the decision. The result comes out one clock after the message strobe. It is an accept bit plus a flag for an illegal configuration: a lowest-priority broadcast while cluster addressing is selected.

A two-state machine controls the timing. In ST_IDLE no result is presented. The transition T_CAPTURE (msg_valid high) moves to ST_RESULT, where res_valid is high for that cycle. T_CHAIN (msg_valid high again) stays in ST_RESULT. T_RELEASE (msg_valid low) returns to ST_IDLE. The accept and illegal outputs keep their last value until the next message.

Top module: `irq_dest_filter`

## Requirements
- R1: After reset the format register holds 1111 (flat). When cfg_fmt_we is high at a clock edge, the register takes cfg_fmt_data. Messages use the value held at the clock edge where they are captured.
- R2: Flat mode (format 1111), logical destination mode (msg_logical=1), shorthand 00: accept is 1 exactly when msg_dest AND logical_id is nonzero.
- R3: In logical destination mode with shorthand 00, a destination of 8'hFF is accepted in either format and for any logical_id, unless R11 applies.
- R4: Cluster mode (format 0000), logical mode, shorthand 00: accept is 1 exactly when msg_dest[7:4] equals logical_id[7:4] (the cluster address) and msg_dest[3:0] AND logical_id[3:0] (the member bits) is nonzero.
- R5: Any format value other than 1111 or 0000 behaves exactly as cluster mode.
- R6: Physical destination mode (msg_logical=0), shorthand 00: accept is 1 when msg_dest equals phys_id or msg_dest is 8'hFF.
- R7: Shorthand 01 (self): accept is 1 exactly when sender_id equals phys_id. The destination and the destination mode have no effect.
- R8: Shorthand 10 (all including self): accept is 1 regardless of destination, destination mode and sender, unless R11 applies.
- R9: Shorthand 11 (all excluding self): accept is 1 exactly when sender_id differs from phys_id, unless R11 applies.
- R10: res_valid is high in the cycle after each cycle in which msg_valid is high, and low otherwise. res_accept and res_illegal are 0 after reset and change only on a captured message.
- R11: With a non-flat format and delivery mode 3'b001 (lowest priority), a broadcast raises res_illegal and forces res_accept to 0. A broadcast here is shorthand 10 or 11, or shorthand 00 in logical mode with destination 8'hFF. In every other case res_illegal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt_we | input | 1 | Write strobe for the format register |
| cfg_fmt_data | input | 4 | Format value: 1111 flat, anything else cluster |
| logical_id | input | 8 | Logical ID: [7:4] cluster address, [3:0] member bits |
| phys_id | input | 8 | Physical ID of this unit |
| msg_valid | input | 1 | Message strobe; fields are sampled when high |
| msg_dest | input | 8 | Destination field of the message |
| msg_logical | input | 1 | Destination mode: 1 logical, 0 physical |
| msg_shorthand | input | 2 | 00 none, 01 self, 10 all incl. self, 11 all excl. self |
| msg_deliv | input | 3 | Delivery mode; 3'b001 is lowest priority |
| sender_id | input | 8 | Physical ID of the sending unit |
| res_valid | output | 1 | High one cycle after a message strobe |
| res_accept | output | 1 | This unit accepts the last captured message |
| res_illegal | output | 1 | The last captured message was an illegal lowest-priority broadcast |

## Verification
The assertions take for granted that all message fields are valid in the same cycle as msg_valid. They also assume that a format write landing in that cycle does not yet affect that message, so each property compares the registered outputs with the inputs sampled one edge earlier. The stimulus drives every message field and every format write on the falling edge. Format writes go only in cycles without a message, and each message is held for one cycle only. As a result, every message in the sweeps meets a settled format and a single well-defined set of fields.

// File: rtl/irq_filt_pkg.sv
package irq_filt_pkg;

    localparam int unsigned FMT_W  = 4;
    localparam int unsigned DLV_W  = 3;

    localparam logic [FMT_W-1:0] FMT_FLAT     = '1;
    localparam logic [DLV_W-1:0] DLV_LOWPRI   = 3'b001;

    typedef enum logic [1:0] {
        SH_NONE     = 2'b00,
        SH_SELF     = 2'b01,
        SH_ALL_INCL = 2'b10,
        SH_ALL_EXCL = 2'b11
    } shorthand_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } fsm_e;

endpackage

// File: rtl/irq_fmt_reg.sv
module irq_fmt_reg
    import irq_filt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [FMT_W-1:0] wdata,
    output logic             is_flat
);

    logic [FMT_W-1:0] fmt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= FMT_FLAT;
        end else if (we) begin
            fmt_q <= wdata;
        end
    end

    // Only the all-ones code selects flat; every other code falls back to cluster.
    assign is_flat = (fmt_q == FMT_FLAT);

    a_r1_write_takes: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (is_flat == ($past(wdata) == FMT_FLAT)));

    a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(is_flat));

endmodule

// File: rtl/irq_logical_match.sv
module irq_logical_match #(
    parameter int unsigned ID_W = 8
) (
    input  logic [ID_W-1:0] dest,
    input  logic [ID_W-1:0] lid,
    input  logic            is_flat,
    output logic            hit
);

    localparam int unsigned HALF = ID_W / 2;

    logic [ID_W-1:0] overlap;
    logic            cluster_eq;
    logic            member_any;
    logic            bcast;

    genvar gi;
    generate
        for (gi = 0; gi < ID_W; gi++) begin : g_bit
            assign overlap[gi] = dest[gi] & lid[gi];
        end
    endgenerate

    assign cluster_eq = (dest[ID_W-1:HALF] == lid[ID_W-1:HALF]);
    assign member_any = |overlap[HALF-1:0];
    assign bcast      = &dest;

    always_comb begin
        if (bcast) begin
            hit = 1'b1;
        end else if (is_flat) begin
            hit = |overlap;
        end else begin
            hit = cluster_eq & member_any;
        end
    end

endmodule

// File: rtl/irq_dest_decide.sv
module irq_dest_decide
    import irq_filt_pkg::*;
#(
    parameter int unsigned ID_W = 8
) (
    input  logic [ID_W-1:0]  dest,
    input  logic [ID_W-1:0]  phys_id,
    input  logic [ID_W-1:0]  sender_id,
    input  logic             logical_mode,
    input  logic [1:0]       shorthand,
    input  logic [DLV_W-1:0] deliv,
    input  logic             is_flat,
    input  logic             logical_hit,
    output logic             accept,
    output logic             illegal
);

    shorthand_e sh;
    logic       is_self;
    logic       bcast_msg;
    logic       raw_accept;

    assign sh      = shorthand_e'(shorthand);
    assign is_self = (sender_id == phys_id);

    always_comb begin
        raw_accept = 1'b0;
        bcast_msg  = 1'b0;
        unique case (sh)
            SH_NONE: begin
                bcast_msg  = logical_mode & (&dest);
                raw_accept = logical_mode ? logical_hit
                                          : ((dest == phys_id) | (&dest));
            end
            SH_SELF: begin
                raw_accept = is_self;
            end
            SH_ALL_INCL: begin
                bcast_msg  = 1'b1;
                raw_accept = 1'b1;
            end
            SH_ALL_EXCL: begin
                bcast_msg  = 1'b1;
                raw_accept = !is_self;
            end
        endcase
    end

    assign illegal = !is_flat & (deliv == DLV_LOWPRI) & bcast_msg;
    assign accept  = raw_accept & !illegal;

endmodule

// File: rtl/irq_dest_filter.sv
module irq_dest_filter
    import irq_filt_pkg::*;
#(
    parameter int unsigned ID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_fmt_we,
    input  logic [3:0]       cfg_fmt_data,
    input  logic [ID_W-1:0]  logical_id,
    input  logic [ID_W-1:0]  phys_id,
    input  logic             msg_valid,
    input  logic [ID_W-1:0]  msg_dest,
    input  logic             msg_logical,
    input  logic [1:0]       msg_shorthand,
    input  logic [2:0]       msg_deliv,
    input  logic [ID_W-1:0]  sender_id,
    output logic             res_valid,
    output logic             res_accept,
    output logic             res_illegal
);

    fsm_e state_q, state_d;
    logic is_flat;
    logic logical_hit;
    logic accept_d;
    logic illegal_d;

    irq_fmt_reg u_fmt (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_fmt_we),
        .wdata   (cfg_fmt_data),
        .is_flat (is_flat)
    );

    irq_logical_match #(.ID_W(ID_W)) u_match (
        .dest    (msg_dest),
        .lid     (logical_id),
        .is_flat (is_flat),
        .hit     (logical_hit)
    );

    irq_dest_decide #(.ID_W(ID_W)) u_decide (
        .dest         (msg_dest),
        .phys_id      (phys_id),
        .sender_id    (sender_id),
        .logical_mode (msg_logical),
        .shorthand    (msg_shorthand),
        .deliv        (msg_deliv),
        .is_flat      (is_flat),
        .logical_hit  (logical_hit),
        .accept       (accept_d),
        .illegal      (illegal_d)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (msg_valid) state_d = ST_RESULT;   // T_CAPTURE
            ST_RESULT: state_d = msg_valid ? ST_RESULT       // T_CHAIN
                                           : ST_IDLE;        // T_RELEASE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_accept  <= 1'b0;
            res_illegal <= 1'b0;
        end else if (msg_valid) begin
            res_accept  <= accept_d;
            res_illegal <= illegal_d;
        end
    end

    assign res_valid = (state_q == ST_RESULT);

    a_r10_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> res_valid);

    a_r10_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> (!res_valid && $stable(res_accept) && $stable(res_illegal)));

    a_r11_illegal_blocks_accept: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> !res_accept);

    a_r11_flat_never_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && is_flat) |=> !res_illegal);

    a_r7_self_only: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_shorthand == 2'b01) |=> (res_accept == $past(sender_id == phys_id)));

    a_r9_excl_self: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_shorthand == 2'b11 && sender_id == phys_id) |=> !res_accept);

    a_r8_incl_all: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_shorthand == 2'b10 && msg_deliv != 3'b001) |=> res_accept);

    a_r6_phys_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_shorthand == 2'b00 && !msg_logical && msg_dest == phys_id) |=> res_accept);

endmodule

// File: tb/irq_dest_filter_tb.sv
module irq_dest_filter_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_fmt_we = 1'b0;
    logic [3:0] cfg_fmt_data = 4'h0;
    logic [7:0] logical_id = 8'h00;
    logic [7:0] phys_id = 8'h00;
    logic       msg_valid = 1'b0;
    logic [7:0] msg_dest = 8'h00;
    logic       msg_logical = 1'b0;
    logic [1:0] msg_shorthand = 2'b00;
    logic [2:0] msg_deliv = 3'b000;
    logic [7:0] sender_id = 8'h00;
    logic       res_valid, res_accept, res_illegal;

    int checks = 0;
    int errors = 0;
    logic [3:0] cur_fmt = 4'hF;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dest_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_fmt_we(cfg_fmt_we), .cfg_fmt_data(cfg_fmt_data),
        .logical_id(logical_id), .phys_id(phys_id),
        .msg_valid(msg_valid), .msg_dest(msg_dest), .msg_logical(msg_logical),
        .msg_shorthand(msg_shorthand), .msg_deliv(msg_deliv), .sender_id(sender_id),
        .res_valid(res_valid), .res_accept(res_accept), .res_illegal(res_illegal)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b (fmt=%h lid=%h pid=%h dest=%h log=%b sh=%b dlv=%b snd=%h)",
                     tag, act, exp, cur_fmt, logical_id, phys_id, msg_dest, msg_logical,
                     msg_shorthand, msg_deliv, sender_id);
        end
    endtask

    function automatic logic exp_ill(input logic [3:0] f, input logic [7:0] d,
                                     input logic lg, input logic [1:0] sh, input logic [2:0] dv);
        logic bc;
        bc = (sh == 2'b10) || (sh == 2'b11) || (sh == 2'b00 && lg && d == 8'hFF);
        return (f != 4'hF) && (dv == 3'b001) && bc;
    endfunction

    function automatic logic exp_acc(input logic [3:0] f, input logic [7:0] lid, input logic [7:0] pid,
                                     input logic [7:0] d, input logic lg, input logic [1:0] sh,
                                     input logic [2:0] dv, input logic [7:0] snd);
        if (exp_ill(f, d, lg, sh, dv)) return 1'b0;
        case (sh)
            2'b01: return snd == pid;
            2'b10: return 1'b1;
            2'b11: return snd != pid;
            default: begin
                if (!lg) return (d == pid) || (d == 8'hFF);
                if (d == 8'hFF) return 1'b1;
                if (f == 4'hF) return (d & lid) != 0;
                return (d[7:4] == lid[7:4]) && ((d[3:0] & lid[3:0]) != 0);
            end
        endcase
    endfunction

    task automatic write_fmt(input logic [3:0] v);
        @(negedge clk);
        cfg_fmt_we = 1'b1; cfg_fmt_data = v;
        @(negedge clk);
        cfg_fmt_we = 1'b0;
        cur_fmt = v;
    endtask

    task automatic send(input string tag, input logic [7:0] d, input logic lg,
                        input logic [1:0] sh, input logic [2:0] dv, input logic [7:0] snd);
        @(negedge clk);
        msg_dest = d; msg_logical = lg; msg_shorthand = sh; msg_deliv = dv; sender_id = snd;
        msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
        check({tag, " R10 valid"}, res_valid, 1'b1);
        check({tag, " accept"}, res_accept,
              exp_acc(cur_fmt, logical_id, phys_id, d, lg, sh, dv, snd));
        check({tag, " R11 illegal"}, res_illegal, exp_ill(cur_fmt, d, lg, sh, dv));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] flat_ids [6]    = '{8'h00, 8'h01, 8'h80, 8'h24, 8'hFF, 8'h5A};
        logic [7:0] clus_ids [5]    = '{8'h31, 8'h3F, 8'hE8, 8'hF1, 8'h00};
        logic [7:0] pids     [3]    = '{8'h00, 8'h07, 8'hFE};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state of the outputs
        check("R10 reset valid", res_valid, 1'b0);
        check("R10 reset accept", res_accept, 1'b0);
        check("R10 reset illegal", res_illegal, 1'b0);

        // R1: reset format is flat (flat accepts, cluster would reject)
        logical_id = 8'h11; phys_id = 8'h07;
        send("R1 reset flat", 8'h10, 1'b1, 2'b00, 3'b000, 8'h00);

        // R10: idle cycle keeps outputs, valid low
        @(negedge clk);
        check("R10 idle valid", res_valid, 1'b0);
        check("R10 idle hold", res_accept, 1'b1);

        // R2/R3: flat sweep
        for (int i = 0; i < 6; i++) begin
            logical_id = flat_ids[i];
            for (int d = 0; d < 256; d++)
                send("R2 R3 flat", 8'(d), 1'b1, 2'b00, {2'b00, d[0]}, 8'h00);
        end

        // R6: physical sweep
        for (int p = 0; p < 3; p++) begin
            phys_id = pids[p];
            for (int d = 0; d < 256; d++)
                send("R6 phys", 8'(d), 1'b0, 2'b00, {2'b00, d[1]}, 8'h00);
        end
        phys_id = 8'h07;

        // R1/R4/R3/R11: cluster sweep
        write_fmt(4'h0);
        for (int i = 0; i < 5; i++) begin
            logical_id = clus_ids[i];
            for (int d = 0; d < 256; d++)
                send("R4 R3 R11 cluster", 8'(d), 1'b1, 2'b00, {2'b00, d[0]}, 8'h00);
        end

        // R5: other format codes behave as cluster
        for (int f = 1; f < 15; f += 6) begin
            write_fmt(4'(f));
            logical_id = 8'h3C;
            for (int d = 0; d < 256; d++)
                send("R5 odd fmt", 8'(d), 1'b1, 2'b00, {2'b00, d[0]}, 8'h00);
        end

        // R7/R8/R9/R11: shorthand sweep in both formats
        for (int fi = 0; fi < 2; fi++) begin
            write_fmt(fi == 0 ? 4'hF : 4'h0);
            logical_id = 8'h21;
            for (int sh = 1; sh < 4; sh++)
                for (int s = 0; s < 16; s++)
                    for (int m = 0; m < 4; m++)
                        send("R7 R8 R9 R11 shorthand", (m[0] ? 8'hFF : 8'h40), m[1],
                             2'(sh), (s[0] ? 3'b001 : 3'b000), 8'(s));
        end

        // R1: write back to flat takes effect
        write_fmt(4'hF);
        logical_id = 8'h11;
        send("R1 rewrite flat", 8'h10, 1'b1, 2'b00, 3'b000, 8'h00);

        // R10: back-to-back messages
        @(negedge clk);
        msg_dest = 8'h01; msg_logical = 1'b1; msg_shorthand = 2'b00; msg_deliv = 3'b000;
        msg_valid = 1'b1;
        @(negedge clk);
        check("R10 chain first valid", res_valid, 1'b1);
        check("R10 chain first accept", res_accept, 1'b1);
        msg_dest = 8'h20;
        @(negedge clk);
        msg_valid = 1'b0;
        check("R10 chain second valid", res_valid, 1'b1);
        check("R10 chain second accept", res_accept, 1'b0);
        @(negedge clk);
        check("R10 chain release", res_valid, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule